// File: doc/BRIEF.md
# Block-Mode DMA Channel

This block is one DMA channel that copies a block of 32-bit words between main memory and a peripheral data port. Software sets up three registers through a plain write port. These are a base address, a block-size word and a control word. Writing a control value with the busy bit set launches the job. The block size is the product of the two 16-bit halves of the block-size word. Only two exact control values move data, and each one picks a direction.

Data moves one word at a time. Memory is reached through a request/grant port. A request stays asserted, with address, write flag and write data held steady, until the grant arrives. A grant may carry an error flag that marks the address as invalid. Toward the peripheral there are two valid/ready streams. On the outbound stream the channel holds valid and data until the peripheral takes the word with ready, so the peripheral can apply back-pressure for any number of cycles. On the inbound stream the channel raises ready only while it has room for one word, and the peripheral stalls the channel by holding valid low. When the job ends, for any reason, the address register points just past the last word moved, the busy bit drops and a one-cycle completion interrupt fires.

Top module: `dma_block_channel`

## Requirements
- R1: The number of words moved equals block-size bits [31:16] times bits [15:0]. Memory words are accessed at consecutive addresses that step by 4.
- R2: A base address written to the register has its two low bits cleared, both in the read-back value and on the memory address.
- R3: Control value 0x01000201 reads words from memory and presents each one on the outbound stream. Valid and data hold until ready is seen high.
- R4: Control value 0x01000200 takes each word from the inbound stream, accepted in a cycle when valid and ready are both high, and writes it to memory in order.
- R5: Control bit 24 is the busy bit. Writing it as 1 while idle starts a job, and hardware clears it when the job ends.
- R6: Every job ends with the completion interrupt high for exactly one cycle. While it is high the busy bit already reads 0.
- R7: A control value with bit 24 set that is neither of the two direction codes makes no memory access, clears busy and raises the interrupt.
- R8: When a job ends, the address register holds the aligned base plus 4 times the number of words moved.
- R9: A grant that carries the error flag ends the job early. No further accesses follow, the failed word does not advance the address, busy clears and the interrupt is raised.
- R10: A block size whose product is zero completes with no memory access.
- R11: While busy, writes to any register are ignored, and the control word can still be read.
- R12: While the grant is low, a pending memory request keeps its address and write flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 block size, 2 control |
| cfg_wdata | input | 32 | Register write data |
| addr_rd | output | 32 | Address register read-back |
| blk_rd | output | 32 | Block-size register read-back |
| ctrl_rd | output | 32 | Control register read-back (bit 24 busy) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant, completes the request |
| mem_err | input | 1 | Invalid address, valid with grant |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| out_valid | output | 1 | Outbound word valid |
| out_data | output | 32 | Outbound word |
| out_ready | input | 1 | Peripheral accepts outbound word |
| in_valid | input | 1 | Inbound word valid |
| in_data | input | 32 | Inbound word |
| in_ready | output | 1 | Channel accepts inbound word |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench targets the length product. A design that added the two halves, or used only one of them, moves the wrong number of words and ends at the wrong address. It stalls both streams and the grant, so a channel that drops a word under back-pressure, or moves its address before the grant, gives corrupted data or a wrong final address. It also covers the ways a job can end without moving data, which are an unknown control code, a zero-size product and a grant that carries an error. A design that got any of these wrong would touch memory, hang busy, or count the failed word into the address. It writes all three registers in the middle of a job and expects them unchanged, which catches a register file that accepts writes while busy.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RD, ST_PUSH, ST_PULL, ST_WR, ST_DONE
  } dma_state_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_BLK  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int DW       = 32,
  parameter int BUSY_BIT = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          adv,
  input  logic          finish,
  output logic          start,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] blk_q,
  output logic [DW-1:0] ctrl_q
);
  localparam logic [DW-1:0] ALIGN_MASK = ~DW'(3);
  localparam logic [DW-1:0] STEP       = DW'(4);

  logic busy;
  assign busy  = ctrl_q[BUSY_BIT];
  assign start = wr_en && !busy && (sel == SEL_CTRL) && wdata[BUSY_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      blk_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en && !busy) begin
        case (sel)
          SEL_ADDR: addr_q <= wdata & ALIGN_MASK;
          SEL_BLK:  blk_q  <= wdata;
          SEL_CTRL: ctrl_q <= wdata;
          default:  ;
        endcase
      end
      if (adv)    addr_q <= addr_q + STEP;
      if (finish) ctrl_q[BUSY_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int              DW         = 32,
  parameter int              CNT_W      = 16,
  parameter logic [DW-1:0]   CODE_TO_P  = 32'h0100_0201,
  parameter logic [DW-1:0]   CODE_FROM_P = 32'h0100_0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] ctrl,
  input  logic [DW-1:0] blk,
  output logic          adv,
  output logic          finish,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready
);
  localparam int LEN_W = 2 * CNT_W;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  dma_state_t       state;
  logic [LEN_W-1:0] cnt, len;
  logic [DW-1:0]    data_q;
  logic             irq_q;

  assign len = LEN_W'(blk[2*CNT_W-1:CNT_W]) * LEN_W'(blk[CNT_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_CHECK;
        ST_CHECK: begin
          cnt <= len;
          if (len == '0)               state <= ST_DONE;
          else if (ctrl == CODE_TO_P)   state <= ST_RD;
          else if (ctrl == CODE_FROM_P) state <= ST_PULL;
          else                          state <= ST_DONE;
        end
        ST_RD: if (mem_gnt) begin
          if (mem_err) state <= ST_DONE;
          else begin
            data_q <= mem_rdata;
            state  <= ST_PUSH;
          end
        end
        ST_PUSH: if (out_ready) begin
          cnt   <= cnt - ONE;
          state <= (cnt == ONE) ? ST_DONE : ST_RD;
        end
        ST_PULL: if (in_valid) begin
          data_q <= in_data;
          state  <= ST_WR;
        end
        ST_WR: if (mem_gnt) begin
          if (mem_err) state <= ST_DONE;
          else begin
            cnt   <= cnt - ONE;
            state <= (cnt == ONE) ? ST_DONE : ST_PULL;
          end
        end
        ST_DONE: begin
          irq_q <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == ST_RD) || (state == ST_WR);
    mem_we    = (state == ST_WR);
    mem_wdata = data_q;
    out_valid = (state == ST_PUSH);
    out_data  = data_q;
    in_ready  = (state == ST_PULL);
    adv       = mem_req && mem_gnt && !mem_err;
    finish    = (state == ST_DONE);
  end

  assign irq = irq_q;
endmodule

// File: rtl/dma_block_channel.sv
module dma_block_channel #(
  parameter int DW       = 32,
  parameter int CNT_W    = 16,
  parameter int BUSY_BIT = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] addr_rd,
  output logic [DW-1:0] blk_rd,
  output logic [DW-1:0] ctrl_rd,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          done_irq
);
  logic start, adv, finish;

  dma_regs #(.DW(DW), .BUSY_BIT(BUSY_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .adv(adv), .finish(finish), .start(start),
    .addr_q(addr_rd), .blk_q(blk_rd), .ctrl_q(ctrl_rd)
  );

  dma_mover #(.DW(DW), .CNT_W(CNT_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl_rd), .blk(blk_rd),
    .adv(adv), .finish(finish), .irq(done_irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready)
  );

  assign mem_addr = addr_rd;
endmodule

// File: rtl/dma_block_channel_chk.sv
module dma_block_channel_chk #(
  parameter int DW       = 32,
  parameter int BUSY_BIT = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [DW-1:0] addr_rd,
  input logic [DW-1:0] blk_rd,
  input logic [DW-1:0] ctrl_rd,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [DW-1:0] mem_addr,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          out_ready,
  input logic          done_irq
);
  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_irq_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !ctrl_rd[BUSY_BIT]);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[BUSY_BIT] |-> (!mem_req && !out_valid));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_busy_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && ctrl_rd[BUSY_BIT]) |=> $stable(blk_rd));

  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (addr_rd[1:0] == 2'b00));
endmodule

bind dma_block_channel dma_block_channel_chk #(.DW(DW), .BUSY_BIT(BUSY_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .addr_rd(addr_rd), .blk_rd(blk_rd),
  .ctrl_rd(ctrl_rd), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .done_irq(done_irq)
);

// File: tb/test_dma_block_channel.sv
module test_dma_block_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] addr_rd, blk_rd, ctrl_rd;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_ready, in_valid, in_ready, done_irq;
  logic [31:0] out_data, in_data;

  always #2 clk = ~clk;

  dma_block_channel i_dma_block_channel (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .addr_rd(addr_rd), .blk_rd(blk_rd), .ctrl_rd(ctrl_rd),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .done_irq(done_irq)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [0:255];
  int gnt_wait = 0, wait_c = 0, grants = 0, err_lim = 1 << 30;
  logic [31:0] sink_buf [0:15];
  int sink_n = 0;
  bit sink_block = 0, sink_toggle = 0, tick = 0;
  int src_idx = 0, src_n = 0;
  bit src_gap = 0;
  int irq_cnt = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: grant after gnt_wait stall cycles; error above err_lim word index
  always @(negedge clk) begin
    mem_gnt <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_gnt) begin
      if (wait_c >= gnt_wait) begin
        wait_c <= 0;
        mem_gnt <= 1'b1;
        grants <= grants + 1;
        if (int'(mem_addr[31:2]) >= err_lim) mem_err <= 1'b1;
        else begin
          mem_rdata <= mem[mem_addr[9:2]];
          if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        end
      end else wait_c <= wait_c + 1;
    end
    tick <= ~tick;
    out_ready <= !sink_block && (sink_toggle ? tick : 1'b1);
    in_valid  <= (src_idx < src_n) && (src_gap ? tick : 1'b1);
    in_data   <= 32'hA000 + 32'(src_idx);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done_irq) irq_cnt <= irq_cnt + 1;
    if (out_valid && out_ready) begin
      sink_buf[sink_n[3:0]] <= out_data;
      sink_n <= sink_n + 1;
    end
    if (in_valid && in_ready) src_idx <= src_idx + 1;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic clear_stats();
    grants = 0; sink_n = 0; irq_cnt = 0; src_idx = 0; src_n = 0;
    sink_block = 0; sink_toggle = 0; src_gap = 0; gnt_wait = 0; err_lim = 1 << 30;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (irq_cnt == 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(irq_cnt == 1, req, 32'(irq_cnt), 32'd1);
    chk(ctrl_rd[24] == 1'b0, "R5 busy cleared", ctrl_rd, ctrl_rd & ~32'h0100_0000);
  endtask

  task automatic t_reset();
    chk(ctrl_rd == 0 && addr_rd == 0 && blk_rd == 0, "R5 reset regs", ctrl_rd, 32'd0);
    chk(!done_irq && !mem_req, "R6 reset irq/req", {30'd0, done_irq, mem_req}, 32'd0);
  endtask

  task automatic t_to_periph();
    clear_stats();
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + 32'(i * 17);
    gnt_wait = 2; sink_toggle = 1;
    wr(0, 32'h0000_0043);
    chk(addr_rd == 32'h40, "R2 address aligned", addr_rd, 32'h40);
    wr(1, 32'h0002_0003);
    wr(2, 32'h0100_0201);
    chk(ctrl_rd[24], "R5 busy set", ctrl_rd, 32'h0100_0201);
    wait_done("R6 irq after read job");
    chk(sink_n == 6, "R1 word count 2x3", 32'(sink_n), 32'd6);
    for (int i = 0; i < 6; i++)
      chk(sink_buf[i] == 32'h5A00_0000 + 32'((16 + i) * 17), "R3 outbound data", sink_buf[i],
          32'h5A00_0000 + 32'((16 + i) * 17));
    chk(addr_rd == 32'h58, "R8 final address", addr_rd, 32'h58);
    chk(grants == 6, "R1 memory accesses", 32'(grants), 32'd6);
  endtask

  task automatic t_from_periph();
    clear_stats();
    src_gap = 1; gnt_wait = 1; src_n = 4;
    wr(0, 32'h0000_0100);
    wr(1, 32'h0004_0001);
    wr(2, 32'h0100_0200);
    wait_done("R6 irq after write job");
    for (int i = 0; i < 4; i++)
      chk(mem[64 + i] == 32'hA000 + 32'(i), "R4 memory written", mem[64 + i], 32'hA000 + 32'(i));
    chk(addr_rd == 32'h110, "R8 final address", addr_rd, 32'h110);
    chk(src_idx == 4, "R4 inbound accepted", 32'(src_idx), 32'd4);
  endtask

  task automatic t_unknown();
    clear_stats();
    wr(0, 32'h0000_0200);
    wr(1, 32'h0001_0004);
    wr(2, 32'h0100_0202);
    wait_done("R7 irq on unknown code");
    chk(grants == 0, "R7 no memory access", 32'(grants), 32'd0);
    chk(addr_rd == 32'h200, "R7 address unchanged", addr_rd, 32'h200);
  endtask

  task automatic t_zero();
    clear_stats();
    wr(0, 32'h0000_0080);
    wr(1, 32'h0005_0000);
    wr(2, 32'h0100_0201);
    wait_done("R10 irq on zero size");
    chk(grants == 0 && sink_n == 0, "R10 no access", 32'(grants), 32'd0);
    chk(addr_rd == 32'h80, "R10 address unchanged", addr_rd, 32'h80);
  endtask

  task automatic t_error();
    clear_stats();
    err_lim = 32'h22;
    wr(0, 32'h0000_0080);
    wr(1, 32'h0001_0005);
    wr(2, 32'h0100_0201);
    wait_done("R9 irq on error");
    chk(grants == 3, "R9 stops after error", 32'(grants), 32'd3);
    chk(sink_n == 2, "R9 words delivered", 32'(sink_n), 32'd2);
    chk(addr_rd == 32'h88, "R9 address not advanced on error", addr_rd, 32'h88);
  endtask

  task automatic t_busy_write();
    clear_stats();
    sink_block = 1;
    wr(0, 32'h0000_0000);
    wr(1, 32'h0001_0002);
    wr(2, 32'h0100_0201);
    repeat (10) @(negedge clk);
    wr(2, 32'h0000_0000);
    wr(1, 32'h0009_0009);
    wr(0, 32'h0000_0300);
    chk(ctrl_rd == 32'h0100_0201, "R11 control readable and unchanged", ctrl_rd, 32'h0100_0201);
    chk(blk_rd == 32'h0001_0002, "R11 block unchanged", blk_rd, 32'h0001_0002);
    chk(addr_rd == 32'h4, "R11 address not overwritten", addr_rd, 32'h4);
    sink_block = 0;
    wait_done("R11 job completes");
    chk(sink_n == 2 && addr_rd == 32'h8, "R11 original job kept", addr_rd, 32'h8);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_to_periph();
    t_from_periph();
    t_unknown();
    t_zero();
    t_error();
    t_busy_write();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule